// File: doc/BRIEF.md
# Power-Up Reset Time-Out Sequencer

This block keeps the rest of the chip in reset after a power-on or brown-out event. It waits until the supply and the clock can be trusted, then lets the chip run. It works through up to three timed phases in a fixed order:

- A power-up delay, measured in timebase ticks. A strap can switch this delay off.
- An oscillator start-up count, measured in oscillator periods. This phase exists only when a crystal is the clock source.
- A short lock delay for the frequency multiplier. This phase exists only when the oscillator mode has the multiplier switched on.

When the last phase that applies has finished, the internal reset release goes high. It stays high until the next qualifying reset.

The delays are counted with one shared counter in the `clk` domain. Two single-cycle strobes feed it:

- `tick` comes from a free-running timebase. Its nominal period is 1 ms, so the defaults of 72 and 2 give 72 ms and 2 ms.
- `osc_pulse` marks each period of the oscillator.

A power-on pulse resets the sequencer asynchronously. A brown-out pulse restarts it on the next clock. The oscillator mode and the strap must be stable while a sequence runs.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_in` is high, `phase` is 0 (power-up delay) and `rst_release` is low, without waiting for a clock edge.
- R2: With `pwrt_en` high, phase 0 lasts exactly PWRT_TICKS `tick` strobes. With `pwrt_en` low, phase 0 lasts one clock and consumes no tick.
- R3: In crystal modes (`osc_mode` 00 and 01), phase 1 (start-up count) lasts exactly OST_CYCLES `osc_pulse` strobes. Oscillator strobes seen in any other phase are not counted.
- R4: In modes where `osc_mode[1]` is 1 (RC or external clock), phase 1 is never entered.
- R5: In modes where `osc_mode[0]` is 1, phase 2 (multiplier lock) follows the previous phase and lasts exactly PLL_TICKS ticks. When `osc_mode[0]` is 0, phase 2 never occurs.
- R6: Phases only advance in the order 0, 1, 2, 3, skipping those that do not apply. Phase 3 means the chip is running.
- R7: A `bor_in` pulse in any phase returns the sequencer to phase 0 with a cleared count on the next clock, and the sequence then runs again in full.
- R8: `rst_release` is high exactly when `phase` is 3. Once high, it stays high until `por_in` or `bor_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running sequencer clock |
| por_in | input | 1 | Power-on reset, active high, asynchronous |
| bor_in | input | 1 | Brown-out reset pulse, active high, synchronous |
| tick | input | 1 | One-cycle timebase strobe |
| osc_pulse | input | 1 | One-cycle strobe per oscillator period |
| pwrt_en | input | 1 | Enable strap for the power-up delay |
| osc_mode | input | 2 | Bit 1: no crystal (RC or external clock). Bit 0: multiplier on. |
| phase | output | 2 | Current phase: 0 power-up, 1 start-up count, 2 lock delay, 3 running |
| rst_release | output | 1 | High when the chip may leave reset |

## Verification
All four oscillator modes are run with the strap both set and cleared. Ticks and oscillator strobes arrive at different rates and keep arriving through every phase. For each run, the bench records which phases were visited and how many strobes of each kind each phase consumed. This separates a phase that was skipped from one that was counted on the wrong strobe or with an off-by-one limit. Directed cases then cover:
- a brown-out in the middle of the start-up count, followed by a full re-run;
- a brown-out while running;
- a power-on assertion between clock edges;
- a long stretch of activity after release, which must leave the release high.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int PWRT_TICKS = 72,
  parameter int OST_CYCLES = 1024,
  parameter int PLL_TICKS  = 2
) (
  input  logic       clk,
  input  logic       por_in,
  input  logic       bor_in,
  input  logic       tick,
  input  logic       osc_pulse,
  input  logic       pwrt_en,
  input  logic [1:0] osc_mode,
  output logic [1:0] phase,
  output logic       rst_release
);
  localparam int MAX_A = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
  localparam int MAX_L = (MAX_A > OST_CYCLES) ? MAX_A : OST_CYCLES;
  localparam int CW    = $clog2(MAX_L + 1);

  localparam logic [1:0] PH_PWRT = 2'd0;
  localparam logic [1:0] PH_OST  = 2'd1;
  localparam logic [1:0] PH_PLL  = 2'd2;
  localparam logic [1:0] PH_RUN  = 2'd3;

  logic [1:0]    ph, ph_nxt;
  logic [CW-1:0] cnt, lim;
  logic          ev, done;

  assign ev = (ph == PH_OST) ? osc_pulse : tick;

  always_comb begin
    case (ph)
      PH_PWRT: lim = CW'(PWRT_TICKS - 1);
      PH_OST:  lim = CW'(OST_CYCLES - 1);
      default: lim = CW'(PLL_TICKS - 1);
    endcase
  end

  assign done = ((ph == PH_PWRT) && !pwrt_en) || (ev && (cnt == lim));

  always_comb begin
    case (ph)
      PH_PWRT: ph_nxt = osc_mode[1] ? (osc_mode[0] ? PH_PLL : PH_RUN) : PH_OST;
      PH_OST:  ph_nxt = osc_mode[0] ? PH_PLL : PH_RUN;
      default: ph_nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or posedge por_in) begin
    if (por_in) begin
      ph  <= PH_PWRT;
      cnt <= '0;
    end else if (bor_in) begin
      ph  <= PH_PWRT;
      cnt <= '0;
    end else if (ph != PH_RUN) begin
      if (done) begin
        ph  <= ph_nxt;
        cnt <= '0;
      end else if (ev) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign phase       = ph;
  assign rst_release = (ph == PH_RUN);
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk,
  input logic       por_in,
  input logic       bor_in,
  input logic       osc_pulse,
  input logic       pwrt_en,
  input logic [1:0] osc_mode,
  input logic [1:0] phase,
  input logic       rst_release
);
  // R1
  por_hold_chk: assert property (@(posedge clk) por_in |-> (!rst_release && phase == 2'd0));

  // R2
  pwrt_skip_chk: assert property (@(posedge clk) disable iff (por_in)
    (!pwrt_en && phase == 2'd0 && !bor_in) |=> (phase != 2'd0));

  // R3
  ost_wait_chk: assert property (@(posedge clk) disable iff (por_in)
    (phase == 2'd1 && !osc_pulse && !bor_in) |=> (phase == 2'd1));

  // R4
  no_ost_chk: assert property (@(posedge clk) disable iff (por_in)
    (osc_mode[1] && phase == 2'd0 && !bor_in) |=> (phase != 2'd1));

  // R5
  no_pll_chk: assert property (@(posedge clk) disable iff (por_in)
    (!osc_mode[0] && phase != 2'd2 && !bor_in) |=> (phase != 2'd2));

  // R6
  ost_order_chk: assert property (@(posedge clk) disable iff (por_in)
    (phase == 2'd1 && !bor_in) |=> (phase != 2'd0));

  // R6
  pll_order_chk: assert property (@(posedge clk) disable iff (por_in)
    (phase == 2'd2 && !bor_in) |=> (phase == 2'd2 || phase == 2'd3));

  // R7
  bor_restart_chk: assert property (@(posedge clk) disable iff (por_in)
    bor_in |=> (phase == 2'd0 && !rst_release));

  // R8
  release_hold_chk: assert property (@(posedge clk) disable iff (por_in)
    (rst_release && !bor_in) |=> rst_release);
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk(clk), .por_in(por_in), .bor_in(bor_in), .osc_pulse(osc_pulse),
  .pwrt_en(pwrt_en), .osc_mode(osc_mode), .phase(phase), .rst_release(rst_release)
);

// File: tb/pwrup_seq_test.sv
module pwrup_seq_test;
  localparam int P_T = 5;
  localparam int O_C = 8;
  localparam int L_T = 3;

  // mode, strap, visited-phase mask (bit n = phase n), power-up ticks, osc pulses, lock ticks
  localparam int VEC [8][6] = '{
    '{0, 1, 11, P_T, O_C, 0  },
    '{1, 1, 15, P_T, O_C, L_T},
    '{2, 1,  9, P_T, 0,   0  },
    '{3, 1, 13, P_T, 0,   L_T},
    '{0, 0, 11, 0,   O_C, 0  },
    '{1, 0, 15, 0,   O_C, L_T},
    '{2, 0,  9, 0,   0,   0  },
    '{3, 0, 13, 0,   0,   L_T}
  };

  logic       clk = 1'b0;
  logic       por_in = 1'b1;
  logic       bor_in = 1'b0;
  logic       tick = 1'b0;
  logic       osc_pulse = 1'b0;
  logic       pwrt_en = 1'b1;
  logic [1:0] osc_mode = 2'd0;
  logic [1:0] phase;
  logic       rst_release;

  int checks = 0;
  int fails  = 0;
  int mask, pc, oc, lc;

  always #2 clk = ~clk;

  pwrup_seq #(.PWRT_TICKS(P_T), .OST_CYCLES(O_C), .PLL_TICKS(L_T)) uut (
    .clk(clk), .por_in(por_in), .bor_in(bor_in), .tick(tick), .osc_pulse(osc_pulse),
    .pwrt_en(pwrt_en), .osc_mode(osc_mode), .phase(phase), .rst_release(rst_release)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic restart(input logic [1:0] m, input logic en);
    osc_mode = m; pwrt_en = en; bor_in = 1'b1; tick = 1'b0; osc_pulse = 1'b0;
    @(negedge clk);
    bor_in = 1'b0;
  endtask

  task automatic run_to_release();
    logic [1:0] p;
    mask = 0; pc = 0; oc = 0; lc = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      p = phase;
      mask |= (1 << p);
      if (p == 2'd3) break;
      tick      = (cyc % 3 == 2);
      osc_pulse = (cyc % 2 == 1);
      if (p == 2'd0 && tick)      pc++;
      if (p == 2'd1 && osc_pulse) oc++;
      if (p == 2'd2 && tick)      lc++;
      @(negedge clk);
    end
    tick = 1'b0; osc_pulse = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase, 0);
    chk("R1 release in reset", rst_release, 0);
    por_in = 1'b0;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      restart(VEC[v][0][1:0], VEC[v][1] != 0);
      chk("R6 phase after restart", phase, 0);
      run_to_release();
      chk("R4 R5 R6 visited phases", mask, VEC[v][2]);
      chk("R2 power-up ticks", pc, VEC[v][3]);
      chk("R3 start-up pulses", oc, VEC[v][4]);
      chk("R5 lock ticks", lc, VEC[v][5]);
      chk("R8 release at end", rst_release, 1);
    end

    // R8: release stays high under activity
    for (int i = 0; i < 30; i++) begin
      tick = (i % 2 == 0); osc_pulse = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0; osc_pulse = 1'b0;
    chk("R8 release held", rst_release, 1);
    chk("R8 phase held", phase, 3);

    // R7: brown-out in the middle of the start-up count
    restart(2'd1, 1'b1);
    for (int i = 0; i < 200 && phase != 2'd1; i++) begin
      tick = (i % 3 == 2);
      @(negedge clk);
    end
    tick = 1'b0;
    osc_pulse = 1'b1; @(negedge clk); osc_pulse = 1'b0;
    chk("R7 reached start-up", phase, 1);
    bor_in = 1'b1; @(negedge clk); bor_in = 1'b0;
    chk("R7 phase after brown-out", phase, 0);
    chk("R7 release after brown-out", rst_release, 0);
    run_to_release();
    chk("R7 rerun power-up ticks", pc, P_T);
    chk("R7 rerun start-up pulses", oc, O_C);
    chk("R7 rerun lock ticks", lc, L_T);

    // R7: brown-out while running
    bor_in = 1'b1; @(negedge clk); bor_in = 1'b0;
    chk("R7 release drops from run", rst_release, 0);
    run_to_release();
    chk("R8 release again", rst_release, 1);

    // R1: power-on takes effect between edges
    #1 por_in = 1'b1;
    #0.5;
    chk("R1 asynchronous release drop", rst_release, 0);
    chk("R1 asynchronous phase", phase, 0);
    @(negedge clk);
    por_in = 1'b0;
    @(negedge clk);
    chk("R1 hold after power-on", phase, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule